// File: doc/BRIEF.md
# Vectored Daisy-Chain Interrupt Controller

This block gathers interrupt requests from a row of device slots and resolves them for one processor that fields every interrupt. Each slot carries a two-bit priority level and a vector that names it. Among pending requests, the level arbiter picks the highest level that lies strictly above the processor's two-bit mask. The processor then runs an acknowledge cycle for that level.

During the acknowledge cycle a grant enters the chain at slot 0 and moves toward higher slot numbers. A slot that has no pending request at the acknowledged level passes the grant on. The first slot with such a request absorbs the grant, and its vector and slot index are returned to the processor. The pending request of that slot is then cleared.

If the grant runs off the end of the chain for a whole timeout window, the cycle closes with an error flag and no vector. The devices themselves only request, pass or take the grant, and supply a vector. All sequencing is in the processor-side logic.

Top module: `irq_chain_ctrl`

## Requirements
- R1: A one-cycle pulse on a slot's set bit makes that slot pending from the next cycle. The request stays pending until the slot is acknowledged or its cancel bit is pulsed. A cancel removes the request without any acknowledge.
- R2: `int_req_o` is high exactly when some pending slot has a level strictly greater than `cpu_mask_i`, and `int_level_o` then gives the highest such level. Level 0 can therefore never interrupt.
- R3: An acknowledge cycle (`ack_busy_o` high) starts only in the cycle after `int_req_o` was high. It latches that level on `ack_level_o`, and no slot absorbs the grant outside an acknowledge cycle.
- R4: Among slots pending at the acknowledged level, the one with the lowest index absorbs the grant. The others are served in ascending index order in later cycles.
- R5: After a successful absorb, `ack_done_o` pulses for one cycle with `ack_err_o`=0, `ack_vec_o` equal to the winner's vector and `ack_slot_o` equal to its index. The pulse comes two clock edges after the edge that made an eligible request pending, when the sequencer is idle.
- R6: The absorbing slot's request is cleared at the same edge that raises `ack_done_o`. Other pending requests are left untouched.
- R7: A request at a higher eligible level is acknowledged before a lower-level one, whatever the slot positions.
- R8: If no slot absorbs during `TIMEOUT_CYC` acknowledge cycles, `ack_done_o` pulses with `ack_err_o`=1, `ack_vec_o`=0 and `ack_slot_o`=0.
- R9: When a slot's set and cancel pulse in the same cycle, set wins and the request becomes pending. A cancel in the cycle where arbitration picks that request still lets the acknowledge start, and the acknowledge then ends in a timeout.
- R10: After reset no request is pending and `int_req_o`, `ack_busy_o`, `ack_done_o`, `ack_err_o` and `ack_vec_o` are 0.
- R11: While an acknowledge cycle runs, `ack_level_o` does not change, even if a higher level becomes pending. A slot that becomes pending at the acknowledged level during the window absorbs the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_set_i | input | N_SLOTS | Per-slot request pulse |
| dev_cancel_i | input | N_SLOTS | Per-slot request withdrawal pulse |
| dev_level_i | input | 2*N_SLOTS | Per-slot priority level, slot g in bits [2g+1:2g] |
| dev_vector_i | input | VEC_W*N_SLOTS | Per-slot vector, slot g in bits [VEC_W*g +: VEC_W] |
| cpu_mask_i | input | 2 | Processor priority mask |
| int_req_o | output | 1 | An eligible request is pending |
| int_level_o | output | 2 | Highest eligible pending level |
| ack_busy_o | output | 1 | Acknowledge cycle in progress (grant driven) |
| ack_level_o | output | 2 | Level being or last acknowledged |
| ack_done_o | output | 1 | One-cycle acknowledge completion pulse |
| ack_err_o | output | 1 | Completion had no vector (timeout) |
| ack_vec_o | output | VEC_W | Vector returned by the absorbing slot |
| ack_slot_o | output | max(1,clog2(N_SLOTS)) | Index of the absorbing slot |

## Verification
Two things can land in the same cycle: a device's withdrawal and the arbitration step that has just chosen its request. The bench pulses a slot's cancel in exactly the cycle where the request first shows as pending. It expects the acknowledge to start anyway, to drive the grant for exactly `TIMEOUT_CYC` cycles and to close with the error flag and a zero vector. A second collision is a set and a cancel in one cycle on one slot, which must leave the request pending and lead to a normal vector read. A third is a new request arriving while the grant is already out. At the acknowledged level such a request must be absorbed within the window, and at a higher level it must wait without moving `ack_level_o`.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 1 << LVL_W;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_GRANT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic valid;
        lvl_t level;
    } lvl_pick_t;

    // A level may interrupt only when strictly above the processor mask.
    function automatic logic lvl_above(input lvl_t lvl, input lvl_t mask);
        return lvl > mask;
    endfunction

endpackage

// File: rtl/irqc_slot.sv
// One device position on the grant chain: holds its request and
// either passes the incoming grant or absorbs it.
module irqc_slot
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic cancel_i,
    input  lvl_t level_i,
    input  lvl_t ack_level_i,
    input  logic grant_i,
    output logic pending_o,
    output logic absorb_o,
    output logic grant_o
);

    logic pending_q;

    assign absorb_o  = grant_i & pending_q & (level_i == ack_level_i);
    assign grant_o   = grant_i & ~absorb_o;
    assign pending_o = pending_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
        end else if (set_i) begin
            pending_q <= 1'b1;
        end else if (cancel_i || absorb_o) begin
            pending_q <= 1'b0;
        end
    end

endmodule

// File: rtl/irqc_level_arb.sv
// Picks the highest pending level that lies above the mask.
module irqc_level_arb
    import irqc_pkg::*;
#(
    parameter int N_SLOTS = 8
)
(
    input  logic [N_SLOTS-1:0] pending_i,
    input  lvl_t [N_SLOTS-1:0] level_i,
    input  lvl_t               mask_i,
    output lvl_pick_t          pick_o
);

    logic [NUM_LVL-1:0] lvl_active;

    always_comb begin
        lvl_active = '0;
        for (int s = 0; s < N_SLOTS; s++) begin
            if (pending_i[s]) begin
                lvl_active[level_i[s]] = 1'b1;
            end
        end
    end

    always_comb begin
        pick_o = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (lvl_active[l] && lvl_above(lvl_t'(l), mask_i)) begin
                pick_o.valid = 1'b1;
                pick_o.level = lvl_t'(l);
            end
        end
    end

endmodule

// File: rtl/irqc_ack_seq.sv
// Processor-side acknowledge sequencer: drives the grant, watches for
// an absorber, returns the vector or times out.
module irqc_ack_seq
    import irqc_pkg::*;
#(
    parameter int N_SLOTS     = 8,
    parameter int VEC_W       = 16,
    parameter int TIMEOUT_CYC = 32,
    parameter int SLOT_W      = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
)
(
    input  logic                          clk,
    input  logic                          rst,
    input  lvl_pick_t                     pick_i,
    input  logic [N_SLOTS-1:0]            absorb_i,
    input  logic [N_SLOTS-1:0][VEC_W-1:0] vector_i,
    input  logic                          grant_tail_i,
    output logic                          grant_o,
    output lvl_t                          ack_level_o,
    output logic                          done_o,
    output logic                          err_o,
    output logic [VEC_W-1:0]              vec_o,
    output logic [SLOT_W-1:0]             slot_o
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

    seq_state_e        state_q;
    lvl_t              lvl_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic              err_q;
    logic [VEC_W-1:0]  vec_q;
    logic [SLOT_W-1:0] slot_q;

    logic              taken;
    logic              last_cycle;
    logic [VEC_W-1:0]  win_vec;
    logic [SLOT_W-1:0] win_slot;

    assign grant_o    = (state_q == SEQ_GRANT);
    // The grant reached no one only if it falls off the end of the chain.
    assign taken      = grant_o & ~grant_tail_i;
    assign last_cycle = (cnt_q == CNT_W'(TIMEOUT_CYC - 1));

    always_comb begin
        win_vec  = '0;
        win_slot = '0;
        for (int s = 0; s < N_SLOTS; s++) begin
            if (absorb_i[s]) begin
                win_vec  = win_vec | vector_i[s];
                win_slot = SLOT_W'(s);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            lvl_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            vec_q   <= '0;
            slot_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (pick_i.valid) begin
                        state_q <= SEQ_GRANT;
                        lvl_q   <= pick_i.level;
                        cnt_q   <= '0;
                    end
                end
                SEQ_GRANT: begin
                    if (taken) begin
                        state_q <= SEQ_IDLE;
                        done_q  <= 1'b1;
                        err_q   <= 1'b0;
                        vec_q   <= win_vec;
                        slot_q  <= win_slot;
                    end else if (last_cycle) begin
                        state_q <= SEQ_IDLE;
                        done_q  <= 1'b1;
                        err_q   <= 1'b1;
                        vec_q   <= '0;
                        slot_q  <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign ack_level_o = lvl_q;
    assign done_o      = done_q;
    assign err_o       = err_q;
    assign vec_o       = vec_q;
    assign slot_o      = slot_q;

endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
    import irqc_pkg::*;
#(
    parameter int N_SLOTS     = 8,
    parameter int VEC_W       = 16,
    parameter int TIMEOUT_CYC = 32
)
(
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic [N_SLOTS-1:0]                           dev_set_i,
    input  logic [N_SLOTS-1:0]                           dev_cancel_i,
    input  logic [N_SLOTS*LVL_W-1:0]                     dev_level_i,
    input  logic [N_SLOTS*VEC_W-1:0]                     dev_vector_i,
    input  logic [LVL_W-1:0]                             cpu_mask_i,
    output logic                                         int_req_o,
    output logic [LVL_W-1:0]                             int_level_o,
    output logic                                         ack_busy_o,
    output logic [LVL_W-1:0]                             ack_level_o,
    output logic                                         ack_done_o,
    output logic                                         ack_err_o,
    output logic [VEC_W-1:0]                             ack_vec_o,
    output logic [((N_SLOTS > 1) ? $clog2(N_SLOTS) : 1)-1:0] ack_slot_o
);

    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

    lvl_t [N_SLOTS-1:0]            slot_level;
    logic [N_SLOTS-1:0][VEC_W-1:0] slot_vec;
    logic [N_SLOTS-1:0]            slot_pending;
    logic [N_SLOTS-1:0]            slot_absorb;
    logic [N_SLOTS:0]              chain;
    lvl_pick_t                     pick;
    logic                          seq_grant;
    lvl_t                          seq_level;

    assign chain[0] = seq_grant;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        assign slot_level[g] = dev_level_i[g*LVL_W +: LVL_W];
        assign slot_vec[g]   = dev_vector_i[g*VEC_W +: VEC_W];

        irqc_slot u_slot (
            .clk         (clk),
            .rst         (rst),
            .set_i       (dev_set_i[g]),
            .cancel_i    (dev_cancel_i[g]),
            .level_i     (slot_level[g]),
            .ack_level_i (seq_level),
            .grant_i     (chain[g]),
            .pending_o   (slot_pending[g]),
            .absorb_o    (slot_absorb[g]),
            .grant_o     (chain[g+1])
        );
    end

    irqc_level_arb #(.N_SLOTS(N_SLOTS)) u_arb (
        .pending_i (slot_pending),
        .level_i   (slot_level),
        .mask_i    (cpu_mask_i),
        .pick_o    (pick)
    );

    irqc_ack_seq #(
        .N_SLOTS     (N_SLOTS),
        .VEC_W       (VEC_W),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .SLOT_W      (SLOT_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .pick_i       (pick),
        .absorb_i     (slot_absorb),
        .vector_i     (slot_vec),
        .grant_tail_i (chain[N_SLOTS]),
        .grant_o      (seq_grant),
        .ack_level_o  (seq_level),
        .done_o       (ack_done_o),
        .err_o        (ack_err_o),
        .vec_o        (ack_vec_o),
        .slot_o       (ack_slot_o)
    );

    assign int_req_o   = pick.valid;
    assign int_level_o = pick.level;
    assign ack_busy_o  = seq_grant;
    assign ack_level_o = seq_level;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int N_SLOTS     = 8,
    parameter int VEC_W       = 16,
    parameter int TIMEOUT_CYC = 32
)
(
    input logic               clk,
    input logic               rst,
    input logic               int_req_o,
    input logic [1:0]         int_level_o,
    input logic [1:0]         cpu_mask_i,
    input logic               ack_busy_o,
    input logic [1:0]         ack_level_o,
    input logic               ack_done_o,
    input logic               ack_err_o,
    input logic [VEC_W-1:0]   ack_vec_o,
    input logic [N_SLOTS-1:0] slot_absorb
);

    localparam int RUN_W = $clog2(TIMEOUT_CYC + 2);

    logic             busy_d;
    logic [RUN_W-1:0] run_q;

    // Length of the most recent grant window, held after it ends.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_d <= 1'b0;
            run_q  <= '0;
        end else begin
            busy_d <= ack_busy_o;
            if (ack_busy_o && !busy_d) begin
                run_q <= RUN_W'(1);
            end else if (ack_busy_o && run_q != {RUN_W{1'b1}}) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    p_eligible_level_r2: assert property (@(posedge clk) disable iff (rst)
        int_req_o |-> (int_level_o > cpu_mask_i));

    p_ack_after_request_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_busy_o) |-> $past(int_req_o));

    p_absorb_in_window_r3: assert property (@(posedge clk) disable iff (rst)
        (slot_absorb != '0) |-> ack_busy_o);

    p_single_absorber_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_absorb));

    p_done_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        ack_done_o |=> !ack_done_o);

    p_done_ends_window_r5: assert property (@(posedge clk) disable iff (rst)
        ack_done_o |-> ($past(ack_busy_o) && !ack_busy_o));

    p_err_no_vector_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_done_o && ack_err_o) |-> (ack_vec_o == '0));

    p_err_full_window_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_done_o && ack_err_o) |-> (run_q == RUN_W'(TIMEOUT_CYC)));

    p_window_bounded_r8: assert property (@(posedge clk) disable iff (rst)
        ack_busy_o |-> (run_q <= RUN_W'(TIMEOUT_CYC)));

    p_level_locked_r11: assert property (@(posedge clk) disable iff (rst)
        (ack_busy_o && busy_d) |-> $stable(ack_level_o));

endmodule

bind irq_chain_ctrl irqc_checker #(
    .N_SLOTS     (N_SLOTS),
    .VEC_W       (VEC_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .int_req_o   (int_req_o),
    .int_level_o (int_level_o),
    .cpu_mask_i  (cpu_mask_i),
    .ack_busy_o  (ack_busy_o),
    .ack_level_o (ack_level_o),
    .ack_done_o  (ack_done_o),
    .ack_err_o   (ack_err_o),
    .ack_vec_o   (ack_vec_o),
    .slot_absorb (slot_absorb)
);

// File: tb/irq_chain_ctrl_tb.sv
`timescale 1ns/1ps
module irq_chain_ctrl_tb;

    localparam int N  = 4;
    localparam int VW = 16;
    localparam int TO = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  set_b = '0;
    logic [N-1:0]  cancel_b = '0;
    logic [2*N-1:0] levels = '0;
    logic [N*VW-1:0] vectors;
    logic [1:0]    mask = '0;
    logic          int_req;
    logic [1:0]    int_level;
    logic          busy;
    logic [1:0]    ack_level;
    logic          done;
    logic          err;
    logic [VW-1:0] vec;
    logic [1:0]    slot;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    function automatic logic [VW-1:0] vec_of(input int i);
        return VW'(16'h1111 * (i + 1));
    endfunction

    for (genvar g = 0; g < N; g++) begin : g_vec
        assign vectors[g*VW +: VW] = vec_of(g);
    end

    irq_chain_ctrl #(.N_SLOTS(N), .VEC_W(VW), .TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst(rst),
        .dev_set_i(set_b), .dev_cancel_i(cancel_b),
        .dev_level_i(levels), .dev_vector_i(vectors),
        .cpu_mask_i(mask),
        .int_req_o(int_req), .int_level_o(int_level),
        .ack_busy_o(busy), .ack_level_o(ack_level),
        .ack_done_o(done), .ack_err_o(err),
        .ack_vec_o(vec), .ack_slot_o(slot)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_lvl(input int i, input logic [1:0] l);
        levels[i*2 +: 2] = l;
    endtask

    // Drive a one-cycle set pulse; return at the falling edge after it,
    // where the new pending state is visible.
    task automatic pulse_set(input logic [N-1:0] m);
        @(negedge clk) set_b = m;
        @(negedge clk) set_b = '0;
    endtask

    task automatic wait_done(input int lim, output logic got);
        got = 1'b0;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            if (done) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(!int_req, "R10 int_req", 32'(int_req), 0);
        check(!busy, "R10 busy", 32'(busy), 0);
        check(!done && !err, "R10 done/err", {30'd0, done, err}, 0);
        check(vec == '0, "R10 vec", 32'(vec), 0);

        // R2 R3 R5 R6 R1: single slot, every level against every mask
        for (int i = 0; i < N; i++) begin
            for (int l = 0; l < 4; l++) begin
                for (int m = 0; m < 4; m++) begin
                    logic elig;
                    elig = (l > m);
                    mask = 2'(m);
                    set_lvl(i, 2'(l));
                    pulse_set(N'(1) << i);
                    check(int_req == elig, "R2 int_req", 32'(int_req), 32'(elig));
                    if (elig) begin
                        check(int_level == 2'(l), "R2 int_level", 32'(int_level), 32'(l));
                        @(negedge clk);
                        check(busy && ack_level == 2'(l) && !done, "R3 grant level",
                              {busy, 29'd0, ack_level}, {1'b1, 29'd0, 2'(l)});
                        @(negedge clk);
                        check(done && !err, "R5 done latency", {30'd0, done, err}, 32'h2);
                        check(vec == vec_of(i), "R5 vector", 32'(vec), 32'(vec_of(i)));
                        check(slot == 2'(i), "R5 slot", 32'(slot), 32'(i));
                        check(!int_req && !busy, "R6 request cleared",
                              {30'd0, int_req, busy}, 0);
                    end else begin
                        @(negedge clk);
                        check(!busy, "R3 masked no ack", 32'(busy), 0);
                        cancel_b = N'(1) << i;
                        @(negedge clk) cancel_b = '0;
                        mask = 2'd0;
                        #1;
                        check(!int_req, "R1 cancel removes", 32'(int_req), 0);
                        @(negedge clk);
                        check(!busy, "R1 cancel no ack", 32'(busy), 0);
                    end
                end
            end
        end

        // R4 R6: all subsets at one level, served front to back
        mask = 2'd1;
        for (int i = 0; i < N; i++) set_lvl(i, 2'd2);
        for (int s = 1; s < (1 << N); s++) begin
            pulse_set(N'(s));
            for (int i = 0; i < N; i++) begin
                if (s[i]) begin
                    wait_done(10, got);
                    check(got && slot == 2'(i), "R4 chain order", 32'(slot), 32'(i));
                    check(vec == vec_of(i) && !err, "R6 vector kept", 32'(vec), 32'(vec_of(i)));
                end
            end
            @(negedge clk);
            check(!int_req && !busy, "R6 all served", {30'd0, int_req, busy}, 0);
        end

        // R7: higher level wins regardless of position
        mask = 2'd0;
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                if (a != b) begin
                    for (int la = 1; la < 3; la++) begin
                        for (int lb = la + 1; lb < 4; lb++) begin
                            set_lvl(a, 2'(la));
                            set_lvl(b, 2'(lb));
                            pulse_set((N'(1) << a) | (N'(1) << b));
                            wait_done(10, got);
                            check(got && slot == 2'(b) && ack_level == 2'(lb),
                                  "R7 higher first", 32'(slot), 32'(b));
                            wait_done(10, got);
                            check(got && slot == 2'(a), "R7 lower second", 32'(slot), 32'(a));
                        end
                    end
                end
            end
        end

        // R1: masked request is held and served once the mask drops
        mask = 2'd3;
        set_lvl(2, 2'd1);
        pulse_set(4'b0100);
        repeat (4) @(negedge clk);
        check(!busy && !int_req, "R1 held while masked", {30'd0, busy, int_req}, 0);
        mask = 2'd0;
        wait_done(10, got);
        check(got && slot == 2'd2 && !err, "R1 held request served", 32'(slot), 2);

        // R9 R8: cancel in the arbitration cycle -> timeout
        set_lvl(1, 2'd2);
        @(negedge clk) set_b = 4'b0010;
        @(negedge clk) begin set_b = '0; cancel_b = 4'b0010; end
        @(negedge clk) cancel_b = '0;
        check(busy && !int_req, "R9 ack starts after cancel", {30'd0, busy, int_req}, 32'h2);
        begin
            int run;
            run = 1;
            for (int k = 0; k < 50; k++) begin
                @(negedge clk);
                if (!busy) break;
                run++;
            end
            check(run == TO, "R8 window length", 32'(run), 32'(TO));
        end
        check(done && err && vec == '0 && slot == '0, "R8 error completion",
              {14'd0, done, err, vec}, {14'd0, 2'b11, 16'h0});

        // R9: set beats cancel in the same cycle
        set_lvl(2, 2'd3);
        @(negedge clk) begin set_b = 4'b0100; cancel_b = 4'b0100; end
        @(negedge clk) begin set_b = '0; cancel_b = '0; end
        check(int_req && int_level == 2'd3, "R9 set wins", {29'd0, int_req, int_level}, 32'h7);
        wait_done(10, got);
        check(got && !err && slot == 2'd2, "R9 served after tie", 32'(slot), 2);

        // R11: level locked during window; late same-level request absorbs
        set_lvl(1, 2'd2);
        set_lvl(0, 2'd3);
        set_lvl(3, 2'd2);
        @(negedge clk) set_b = 4'b0010;
        @(negedge clk) begin set_b = '0; cancel_b = 4'b0010; end
        @(negedge clk) cancel_b = '0;
        pulse_set(4'b0001);
        check(busy && ack_level == 2'd2, "R11 level locked",
              {busy, 29'd0, ack_level}, {1'b1, 29'd0, 2'd2});
        pulse_set(4'b1000);
        @(negedge clk);
        check(done && !err && slot == 2'd3, "R11 late absorb", {done, err, 28'd0, slot},
              {2'b10, 28'd0, 2'd3});
        check(vec == vec_of(3), "R11 late vector", 32'(vec), 32'(vec_of(3)));
        wait_done(10, got);
        check(got && slot == 2'd0 && ack_level == 2'd3, "R11 higher served next",
              32'(slot), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule